// File: doc/BRIEF.md
# Two/Four-Level FSK Symbol Recovery Path

This block is the digital back end of a paging receiver that is fed by an external frequency demodulator. Two data lines arrive as NRZ levels: line I carries the symbol MSB and line Q the LSB. In two-level operation only line I carries information. The whole block runs on one 76.8 kHz sample clock. Ahead of clock recovery the lines either pass through a 3-of-5 majority filter that removes short glitches, or they bypass it entirely.

A clock-recovery loop follows the selected data. It is a phase counter that wraps once per symbol period. The counter is pulled one step toward each data transition it sees. When the counter reaches mid-symbol, the loop samples the current symbol and raises a one-cycle strobe. The sampled symbols, of one or two bits each, are packed into an 8-bit word with the oldest symbol at the top. When the word is full it is copied to the output, and a ready flag rises. A read strobe from the processor clears the flag.

Top module: `fsk_symbol_path`

## Requirements
- R1: While reset is high, and on the first cycle after it, `sym_word` is 0, `word_ready` is 0 and `sym_tick` is 0.
- R2: With `direct_mode`=1 the registered input lines go to clock recovery with no filtering, and the sent symbols are recovered in order.
- R3: With `direct_mode`=0 each line passes a 3-of-5 majority vote over its newest five samples. Single-cycle pulses of the opposite level, spaced three cycles apart inside a symbol, never change the recovered symbol.
- R4: With `four_level`=0 the symbol is line I alone. Line Q has no effect on the recovered words or on the loop timing, and the sampled LSB is 0.
- R5: The phase counter starts at 0 after reset and wraps every SYM_LEN (48) cycles. With no data transitions, `sym_tick` pulses exactly every 48 cycles and is never high on two consecutive cycles.
- R6: A transition seen at phase 1..23 holds the phase for one cycle. A transition seen at phase 24..47 advances it by two. Data whose symbol period is 47 or 49 cycles is still recovered without error.
- R7: At each tick, four-level mode appends two bits {I,Q} and two-level mode appends one bit I, at the word LSB end. The first symbol after reset ends up in the word MSB.
- R8: When 8 bits have been collected, the word is copied to `sym_word` and `word_ready` goes to 1. `sym_word` then holds until the next word completes.
- R9: `rd_strobe` clears `word_ready` on the next cycle, unless a word completes in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 76.8 kHz sample clock |
| rst | input | 1 | Synchronous active-high reset |
| four_level | input | 1 | 1: two-bit symbols, 0: one-bit symbols |
| direct_mode | input | 1 | 1: bypass the glitch filter, 0: filter |
| line_i | input | 1 | NRZ data line, symbol MSB |
| line_q | input | 1 | NRZ data line, symbol LSB (ignored in two-level mode) |
| rd_strobe | input | 1 | Processor read of the symbol word |
| sym_tick | output | 1 | One-cycle recovered symbol strobe |
| sym_word | output | 8 | Last completed symbol word |
| word_ready | output | 1 | A completed word awaits reading |

## Verification
The in-line assertions check properties that hold on every cycle:
- the symbol strobe is never high on two consecutive cycles;
- the phase counter stays within its period;
- the filter output stays low after a quiet stretch of samples;
- the LSB is masked in two-level mode;
- a read clears the flag;
- the output word is stable between completions.

Only the bench scenarios can show that the loop locks and tracks data that runs fast or slow, that symbols pack in the right order, that glitches are actually rejected, and that the strobe period is 48 cycles.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  typedef enum logic {
    PATH_FILTER = 1'b0,
    PATH_DIRECT = 1'b1
  } path_e;

  localparam int LANES = 2;
endpackage

// File: rtl/fsk_glitch_filter.sv
module fsk_glitch_filter #(
  parameter int WIN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW     = $clog2(WIN + 1);
  localparam int THRESH = WIN / 2 + 1;

  logic [WIN-1:0] win_q;
  logic [WIN-1:0] win_n;
  logic [CW-1:0]  ones;

  // newest sample at bit 0
  assign win_n = {win_q[WIN-2:0], din};

  always_comb begin
    ones = '0;
    for (int k = 0; k < WIN; k++) begin
      ones = ones + CW'(win_n[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
      dout  <= 1'b0;
    end else begin
      win_q <= win_n;
      dout  <= (ones >= CW'(THRESH));
    end
  end

  // R3: a quiet stretch of THRESH samples keeps the vote low next cycle
  a_r3_quiet_window: assert property (@(posedge clk) disable iff (rst)
    (win_q[THRESH-1:0] == '0) |=> !dout);
endmodule

// File: rtl/fsk_clock_recovery.sv
module fsk_clock_recovery #(
  parameter int SYM_LEN = 48
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       four_level,
  input  logic [1:0] data,
  output logic       sym_tick,
  output logic [1:0] sym_val
);
  localparam int PW  = $clog2(SYM_LEN);
  localparam int MID = SYM_LEN / 2;

  logic [1:0]    data_eff;
  logic [1:0]    prev_q;
  logic          edge_seen;
  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_n;
  logic [PW:0]   step;
  logic [PW:0]   sum;

  // two-level: only the MSB line counts
  assign data_eff  = four_level ? data : {data[1], 1'b0};
  assign edge_seen = (data_eff != prev_q);

  always_comb begin
    if (edge_seen && (phase_q != '0) && (phase_q < PW'(MID))) begin
      step = '0;                 // loop early: hold one cycle
    end else if (edge_seen && (phase_q >= PW'(MID))) begin
      step = (PW+1)'(2);         // loop late: extra step
    end else begin
      step = (PW+1)'(1);
    end
    sum = {1'b0, phase_q} + step;
    if (sum >= (PW+1)'(SYM_LEN)) begin
      sum = sum - (PW+1)'(SYM_LEN);
    end
    phase_n = sum[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      phase_q  <= '0;
      sym_tick <= 1'b0;
      sym_val  <= '0;
    end else begin
      prev_q   <= data_eff;
      phase_q  <= phase_n;
      sym_tick <= (phase_q == PW'(MID));
      if (phase_q == PW'(MID)) begin
        sym_val <= data_eff;
      end
    end
  end

  // R5: strobe is a single-cycle pulse
  a_r5_tick_isolated: assert property (@(posedge clk) disable iff (rst)
    sym_tick |=> !sym_tick);

  // R6: phase never leaves its period
  a_r6_phase_bounded: assert property (@(posedge clk) disable iff (rst)
    phase_q < PW'(SYM_LEN));

  // R4: Q never reaches the sampled symbol in two-level mode
  a_r4_q_masked: assert property (@(posedge clk) disable iff (rst)
    (sym_tick && !four_level && $past(!four_level)) |-> (sym_val[0] == 1'b0));
endmodule

// File: rtl/fsk_symbol_packer.sv
module fsk_symbol_packer #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              four_level,
  input  logic              tick,
  input  logic [1:0]        sym,
  input  logic              rd,
  output logic [WORD_W-1:0] word,
  output logic              ready
);
  localparam int CW = $clog2(WORD_W + 2);

  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] shreg_n;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     cnt_n;
  logic              full;

  always_comb begin
    if (four_level) begin
      shreg_n = {shreg_q[WORD_W-3:0], sym};
      cnt_n   = cnt_q + CW'(2);
    end else begin
      shreg_n = {shreg_q[WORD_W-2:0], sym[1]};
      cnt_n   = cnt_q + CW'(1);
    end
    full = tick && (cnt_n >= CW'(WORD_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      word    <= '0;
      ready   <= 1'b0;
    end else begin
      if (tick) begin
        shreg_q <= shreg_n;
        cnt_q   <= full ? '0 : cnt_n;
      end
      if (full) begin
        word  <= shreg_n;
        ready <= 1'b1;
      end else if (rd) begin
        ready <= 1'b0;
      end
    end
  end

  // R9: a read with no completing symbol clears the flag
  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd && !tick) |=> !ready);

  // R8: output word only moves on a symbol strobe
  a_r8_word_holds: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(word));

  // R8: flag only rises after a strobe
  a_r8_ready_after_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(tick));
endmodule

// File: rtl/fsk_symbol_path.sv
module fsk_symbol_path #(
  parameter int SYM_LEN  = 48,
  parameter int FILT_WIN = 5,
  parameter int WORD_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              four_level,
  input  logic              direct_mode,
  input  logic              line_i,
  input  logic              line_q,
  input  logic              rd_strobe,
  output logic              sym_tick,
  output logic [WORD_W-1:0] sym_word,
  output logic              word_ready
);
  import fsk_pkg::*;

  path_e                path;
  logic [LANES-1:0]     in_q;
  logic [LANES-1:0]     lane_filt;
  logic [LANES-1:0]     lane_sel;
  logic [1:0]           sym_val;

  assign path = path_e'(direct_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q <= '0;
    end else begin
      in_q <= {line_i, line_q};
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    fsk_glitch_filter #(.WIN(FILT_WIN)) i_filt (
      .clk  (clk),
      .rst  (rst),
      .din  (in_q[l]),
      .dout (lane_filt[l])
    );
  end

  assign lane_sel = (path == PATH_DIRECT) ? in_q : lane_filt;

  fsk_clock_recovery #(.SYM_LEN(SYM_LEN)) i_rec (
    .clk        (clk),
    .rst        (rst),
    .four_level (four_level),
    .data       (lane_sel),
    .sym_tick   (sym_tick),
    .sym_val    (sym_val)
  );

  fsk_symbol_packer #(.WORD_W(WORD_W)) i_pack (
    .clk        (clk),
    .rst        (rst),
    .four_level (four_level),
    .tick       (sym_tick),
    .sym        (sym_val),
    .rd         (rd_strobe),
    .word       (sym_word),
    .ready      (word_ready)
  );
endmodule

// File: tb/test_fsk_symbol_path.sv
module test_fsk_symbol_path;
  localparam int SL = 48;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       four_level = 1'b1;
  logic       direct_mode = 1'b0;
  logic       line_i = 1'b0;
  logic       line_q = 1'b0;
  logic       man_rd = 1'b0;
  logic       mon_rd = 1'b0;
  logic       auto_rd = 1'b1;
  logic       rd_strobe;
  logic       sym_tick;
  logic [7:0] sym_word;
  logic       word_ready;
  logic [7:0] got[$];
  int         n_chk = 0;
  int         n_bad = 0;

  assign rd_strobe = man_rd | mon_rd;

  always #2 clk = ~clk;

  fsk_symbol_path i_fsk_symbol_path (
    .clk(clk), .rst(rst), .four_level(four_level), .direct_mode(direct_mode),
    .line_i(line_i), .line_q(line_q), .rd_strobe(rd_strobe),
    .sym_tick(sym_tick), .sym_word(sym_word), .word_ready(word_ready)
  );

  always @(negedge clk) begin
    mon_rd <= 1'b0;
    if (auto_rd && word_ready && !mon_rd) begin
      got.push_back(sym_word);
      mon_rd <= 1'b1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic fl, input logic dm);
    rst = 1'b1; four_level = fl; direct_mode = dm;
    line_i = 1'b0; line_q = 1'b0;
    got.delete();
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_sym(input logic [1:0] v, input int len, input bit glitch, input bit qnoise);
    for (int c = 0; c < len; c++) begin
      line_i = v[1];
      line_q = qnoise ? 1'($urandom % 2) : (four_level ? v[0] : 1'b0);
      if (glitch && c >= 3 && c <= 44 && (c % 3) == 1) line_i = ~v[1];
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", int'(word_ready), 0);
    chk("R1", "word in reset", int'(sym_word), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "tick after reset", int'(sym_tick), 0);
    chk("R1", "word after reset", int'(sym_word), 0);
  endtask

  task automatic run_four(input string req, input logic dm, input int per, input logic [1:0] syms[]);
    int nw;
    do_reset(1'b1, dm);
    foreach (syms[k]) send_sym(syms[k], per, 1'b0, 1'b0);
    send_sym(2'b00, SL, 1'b0, 1'b0);
    send_sym(2'b00, SL, 1'b0, 1'b0);
    nw = syms.size() / 4;
    chk(req, "word count", got.size(), nw);
    for (int w = 0; w < nw && w < got.size(); w++) begin
      chk(req, $sformatf("word %0d", w), int'(got[w]),
          int'({syms[4*w], syms[4*w+1], syms[4*w+2], syms[4*w+3]}));
    end
  endtask

  task automatic run_two(input string req, input bit glitch, input bit qnoise, input logic [15:0] bits);
    do_reset(1'b0, 1'b0);
    for (int k = 15; k >= 0; k--) send_sym({bits[k], 1'b0}, SL, glitch, qnoise);
    send_sym(2'b00, SL, 1'b0, qnoise);
    send_sym(2'b00, SL, 1'b0, qnoise);
    chk(req, "word count", got.size(), 2);
    if (got.size() >= 2) begin
      chk(req, "word 0", int'(got[0]), int'(bits[15:8]));
      chk(req, "word 1", int'(got[1]), int'(bits[7:0]));
    end
  endtask

  task automatic t_period();
    int cnt;
    do_reset(1'b1, 1'b1);
    for (int p = 0; p < 2; p++) begin
      while (!sym_tick) @(negedge clk);
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!sym_tick);
      chk("R5", "tick spacing", cnt, SL);
    end
  endtask

  task automatic t_ready();
    auto_rd = 1'b0;
    do_reset(1'b1, 1'b1);
    send_sym(2'b11, SL, 1'b0, 1'b0);
    send_sym(2'b01, SL, 1'b0, 1'b0);
    send_sym(2'b10, SL, 1'b0, 1'b0);
    send_sym(2'b00, SL, 1'b0, 1'b0);
    send_sym(2'b00, SL, 1'b0, 1'b0);
    chk("R8", "ready when full", int'(word_ready), 1);
    chk("R8", "completed word", int'(sym_word), 8'hD8);
    repeat (10) @(negedge clk);
    chk("R8", "ready held unread", int'(word_ready), 1);
    man_rd = 1'b1;
    @(negedge clk);
    man_rd = 1'b0;
    chk("R9", "ready after read", int'(word_ready), 0);
    chk("R8", "word held after read", int'(sym_word), 8'hD8);
    auto_rd = 1'b1;
  endtask

  initial begin
    logic [1:0] s4f[] = '{2'd2, 2'd3, 2'd1, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 2'd1, 2'd2, 2'd2, 2'd0};
    logic [1:0] s4d[] = '{2'd1, 2'd1, 2'd2, 2'd3, 2'd0, 2'd3, 2'd2, 2'd1};
    logic [1:0] strk[];
    strk = new[16];
    foreach (strk[k]) strk[k] = 2'((k * 3 + 1) % 4);

    t_reset();
    run_four("R3 R7 filter four-level", 1'b0, SL, s4f);
    run_four("R2 direct four-level", 1'b1, SL, s4d);
    run_two("R4 R7 two-level Q noise", 1'b0, 1'b1, 16'hB36A);
    run_two("R3 glitch rejection", 1'b1, 1'b0, 16'h5C91);
    t_period();
    run_four("R6 slow data", 1'b1, SL + 1, strk);
    run_four("R6 fast data", 1'b1, SL - 1, strk);
    t_ready();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule